// File: doc/BRIEF.md
# Vector Function-Code Decoder with Reserved-Code Fill

This block sits at the front of a vector coprocessor's execute stage. Each cycle it can take one instruction. It decodes the 6-bit function field into a one-hot set of operation enables. The arithmetic units downstream use these enables to start the real work. The block leaves none of the 64 function codes undefined. Reserved slots in the map fall back to a fill behaviour. Two codes are pure no-ops. Every other unmapped code raises an illegal-code flag.

The block performs the fill behaviour itself, since it needs only an adder per lane. For each lane it adds the two source elements with wraparound and writes the sum into the low slice of that lane's accumulator. It also writes an all-zero destination vector. The high and middle accumulator slices pass through unchanged.

The block registers all outputs, so results appear one clock after the instruction is accepted. When an output is not written, its data port carries the value supplied at the input. This lets a register file write it back unchanged or ignore it.

Top module: `vec_op_decoder`

## Requirements
- R1: After reset, `out_valid`, every bit of `op_en`, `op_noop`, `op_illegal`, `dst_we` and `acc_lo_we` are 0.
- R2: Fill codes are 0x12, 0x16 to 0x1C, 0x1E, 0x1F, 0x2E, 0x2F and 0x38 to 0x3E. A fill code sets `op_en[7]` and `dst_we`, and drives `dst_out` to all zeros.
- R3: For a fill code, each lane i of `acc_lo_out` (bits i*EW+EW-1 down to i*EW) equals (src_a lane i + src_b lane i) mod 2^EW. `acc_lo_we` is 1.
- R4: For a fill code, `acc_hi_out` and `acc_mid_out` equal `acc_hi_in` and `acc_mid_in` as they were at acceptance.
- R5: Codes 0x37 and 0x3F set `op_noop` and raise no write enable. `dst_out` and `acc_lo_out` equal their input values.
- R6: Code 0x02 sets `op_en[1]`, 0x0A sets `op_en[4]`, 0x03 sets `op_en[2]`, 0x0B sets `op_en[5]`, and 0x1D sets `op_en[6]`.
- R7: Code 0x01 sets `op_en[0]`. Codes 0x04 to 0x09 and 0x0C to 0x0F set `op_en[3]`.
- R8: Any other code sets `op_illegal`, raises no write enable, and leaves `dst_out` and `acc_lo_out` equal to their inputs.
- R9: For each accepted instruction, exactly one of `op_en[7:0]`, `op_noop` and `op_illegal` is 1. All of them are 0 when `out_valid` is 0.
- R10: The outputs for an instruction accepted at one rising edge appear after that edge. `out_valid` is 1 only in the cycle after `in_valid` was sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| func | input | 6 | Function field of the instruction |
| src_a | input | LANES*EW | First source vector |
| src_b | input | LANES*EW | Second source vector (element already selected) |
| dst_in | input | LANES*EW | Current destination register contents |
| acc_hi_in | input | LANES*EW | Accumulator high slice |
| acc_mid_in | input | LANES*EW | Accumulator middle slice |
| acc_lo_in | input | LANES*EW | Accumulator low slice |
| out_valid | output | 1 | Decoded result present |
| op_en | output | 8 | One-hot operation enables |
| op_noop | output | 1 | No-operation code decoded |
| op_illegal | output | 1 | Unmapped code decoded |
| dst_we | output | 1 | Destination write enable |
| dst_out | output | LANES*EW | Destination write data |
| acc_lo_we | output | 1 | Low accumulator write enable |
| acc_hi_out | output | LANES*EW | High accumulator slice out |
| acc_mid_out | output | LANES*EW | Middle accumulator slice out |
| acc_lo_out | output | LANES*EW | Low accumulator slice out |

## Verification
The bench builds the block at its default size of 8 lanes of 16 bits. At this size the full 128-bit vectors and all 64 function codes are covered. Random 16-bit elements make the wraparound of the per-lane sum frequent, and directed lanes with all-ones plus one force it on every lane. A sweep over every code and random gaps in `in_valid` exercise the map's range edges and the hold behaviour.

// File: rtl/vdec_pkg.sv
package vdec_pkg;
  localparam int FUNC_W  = 6;
  localparam int NUM_OPS = 8;

  // one-hot enable positions
  localparam int OP_MUL_UFRAC = 0;
  localparam int OP_RND_POS   = 1;
  localparam int OP_MUL_QUANT = 2;
  localparam int OP_MUL_MAC   = 3;
  localparam int OP_RND_NEG   = 4;
  localparam int OP_MAC_QUANT = 5;
  localparam int OP_ACC_READ  = 6;
  localparam int OP_FILL      = 7;

  typedef struct packed {
    logic [NUM_OPS-1:0] en;
    logic               noop;
    logic               illegal;
  } dec_t;
endpackage

// File: rtl/vdec_map.sv
module vdec_map
  import vdec_pkg::*;
(
  input  logic [FUNC_W-1:0] func,
  output dec_t              dec
);
  always_comb begin
    dec = '0;
    case (func) inside
      6'h01:                          dec.en[OP_MUL_UFRAC] = 1'b1;
      6'h02:                          dec.en[OP_RND_POS]   = 1'b1;
      6'h03:                          dec.en[OP_MUL_QUANT] = 1'b1;
      [6'h04:6'h09], [6'h0C:6'h0F]:   dec.en[OP_MUL_MAC]   = 1'b1;
      6'h0A:                          dec.en[OP_RND_NEG]   = 1'b1;
      6'h0B:                          dec.en[OP_MAC_QUANT] = 1'b1;
      6'h1D:                          dec.en[OP_ACC_READ]  = 1'b1;
      6'h12, [6'h16:6'h1C], 6'h1E, 6'h1F,
      6'h2E, 6'h2F, [6'h38:6'h3E]:    dec.en[OP_FILL]      = 1'b1;
      6'h37, 6'h3F:                   dec.noop             = 1'b1;
      default:                        dec.illegal          = 1'b1;
    endcase
  end

  always_comb begin
    a_r9_map_onehot: assert ($onehot({dec.en, dec.noop, dec.illegal}) || $isunknown(func));
  end
endmodule

// File: rtl/vdec_lane_sum.sv
module vdec_lane_sum #(
  parameter int LANES = 8,
  parameter int EW    = 16,
  localparam int VW   = LANES * EW
) (
  input  logic [VW-1:0] a,
  input  logic [VW-1:0] b,
  output logic [VW-1:0] sum
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    // carry out of each lane is dropped: wrapping add
    assign sum[i*EW +: EW] = a[i*EW +: EW] + b[i*EW +: EW];
  end
endmodule

// File: rtl/vec_op_decoder.sv
module vec_op_decoder
  import vdec_pkg::*;
#(
  parameter int LANES = 8,
  parameter int EW    = 16,
  localparam int VW   = LANES * EW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [FUNC_W-1:0] func,
  input  logic [VW-1:0]     src_a,
  input  logic [VW-1:0]     src_b,
  input  logic [VW-1:0]     dst_in,
  input  logic [VW-1:0]     acc_hi_in,
  input  logic [VW-1:0]     acc_mid_in,
  input  logic [VW-1:0]     acc_lo_in,
  output logic              out_valid,
  output logic [NUM_OPS-1:0] op_en,
  output logic              op_noop,
  output logic              op_illegal,
  output logic              dst_we,
  output logic [VW-1:0]     dst_out,
  output logic              acc_lo_we,
  output logic [VW-1:0]     acc_hi_out,
  output logic [VW-1:0]     acc_mid_out,
  output logic [VW-1:0]     acc_lo_out
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  dec_t          dec;
  logic [VW-1:0] lane_sum;

  vdec_map u_map (.func(func), .dec(dec));

  vdec_lane_sum #(.LANES(LANES), .EW(EW)) u_sum (
    .a(src_a), .b(src_b), .sum(lane_sum)
  );

  // next-state
  logic               fill_sel;
  logic               vld_d;
  logic [NUM_OPS-1:0] en_d;
  logic               noop_d, ill_d, dwe_d, awe_d;
  logic [VW-1:0]      dst_d, hi_d, mid_d, lo_d;
  logic               data_ce;

  always_comb begin
    fill_sel = in_valid && dec.en[OP_FILL];
    vld_d    = in_valid;
    en_d     = in_valid ? dec.en : '0;
    noop_d   = in_valid && dec.noop;
    ill_d    = in_valid && dec.illegal;
    dwe_d    = fill_sel;
    awe_d    = fill_sel;
    data_ce  = in_valid;
    dst_d    = fill_sel ? '0 : dst_in;
    lo_d     = fill_sel ? lane_sum : acc_lo_in;
    hi_d     = acc_hi_in;
    mid_d    = acc_mid_in;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_valid  <= 1'b0;
      op_en      <= '0;
      op_noop    <= 1'b0;
      op_illegal <= 1'b0;
      dst_we     <= 1'b0;
      acc_lo_we  <= 1'b0;
    end else begin
      out_valid  <= vld_d;
      op_en      <= en_d;
      op_noop    <= noop_d;
      op_illegal <= ill_d;
      dst_we     <= dwe_d;
      acc_lo_we  <= awe_d;
    end
  end

  // data registers, loaded only with an accepted instruction
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      dst_out     <= '0;
      acc_hi_out  <= '0;
      acc_mid_out <= '0;
      acc_lo_out  <= '0;
    end else if (data_ce) begin
      dst_out     <= dst_d;
      acc_hi_out  <= hi_d;
      acc_mid_out <= mid_d;
      acc_lo_out  <= lo_d;
    end
  end

  // assertions
  a_r1_idle_after_reset: assert property (@(posedge clk)
    !rst_int_n |-> !out_valid && op_en == '0 && !dst_we && !acc_lo_we);
  a_r9_one_flag: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_valid |-> $onehot({op_en, op_noop, op_illegal}));
  a_r9_quiet_idle: assert property (@(posedge clk) disable iff (!rst_int_n)
    !out_valid |-> op_en == '0 && !op_noop && !op_illegal && !dst_we && !acc_lo_we);
  a_r2_fill_writes_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    op_en[OP_FILL] |-> dst_we && acc_lo_we && dst_out == '0);
  a_r4_upper_slices_kept: assert property (@(posedge clk) disable iff (!rst_int_n)
    $past(rst_int_n) && acc_lo_we |-> acc_hi_out == $past(acc_hi_in) && acc_mid_out == $past(acc_mid_in));
  a_r5_noop_no_write: assert property (@(posedge clk) disable iff (!rst_int_n)
    op_noop |-> !dst_we && !acc_lo_we);
  a_r8_illegal_no_write: assert property (@(posedge clk) disable iff (!rst_int_n)
    op_illegal |-> !dst_we && !acc_lo_we);
  a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_int_n)
    $past(rst_int_n) && out_valid |-> $past(in_valid));
endmodule

// File: tb/test_vec_op_decoder.sv
module test_vec_op_decoder;
  localparam int LANES = 8;
  localparam int EW    = 16;
  localparam int VW    = LANES * EW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [5:0]    func;
  logic [VW-1:0] src_a, src_b, dst_in, acc_hi_in, acc_mid_in, acc_lo_in;
  logic          out_valid, op_noop, op_illegal, dst_we, acc_lo_we;
  logic [7:0]    op_en;
  logic [VW-1:0] dst_out, acc_hi_out, acc_mid_out, acc_lo_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  vec_op_decoder #(.LANES(LANES), .EW(EW)) i_vec_op_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .func(func),
    .src_a(src_a), .src_b(src_b), .dst_in(dst_in),
    .acc_hi_in(acc_hi_in), .acc_mid_in(acc_mid_in), .acc_lo_in(acc_lo_in),
    .out_valid(out_valid), .op_en(op_en), .op_noop(op_noop), .op_illegal(op_illegal),
    .dst_we(dst_we), .dst_out(dst_out), .acc_lo_we(acc_lo_we),
    .acc_hi_out(acc_hi_out), .acc_mid_out(acc_mid_out), .acc_lo_out(acc_lo_out)
  );

  // expected {illegal, noop, en[7:0]}
  function automatic logic [9:0] exp_flags(input logic [5:0] f);
    logic [9:0] r = '0;
    if (f == 6'h01) r[0] = 1'b1;
    else if (f == 6'h02) r[1] = 1'b1;
    else if (f == 6'h03) r[2] = 1'b1;
    else if ((f >= 6'h04 && f <= 6'h09) || (f >= 6'h0C && f <= 6'h0F)) r[3] = 1'b1;
    else if (f == 6'h0A) r[4] = 1'b1;
    else if (f == 6'h0B) r[5] = 1'b1;
    else if (f == 6'h1D) r[6] = 1'b1;
    else if (f == 6'h12 || (f >= 6'h16 && f <= 6'h1C) || f == 6'h1E || f == 6'h1F ||
             f == 6'h2E || f == 6'h2F || (f >= 6'h38 && f <= 6'h3E)) r[7] = 1'b1;
    else if (f == 6'h37 || f == 6'h3F) r[8] = 1'b1;
    else r[9] = 1'b1;
    return r;
  endfunction

  function automatic logic [VW-1:0] exp_sum(input logic [VW-1:0] a, input logic [VW-1:0] b);
    logic [VW-1:0] s;
    for (int i = 0; i < LANES; i++) begin
      logic [EW:0] t = {1'b0, a[i*EW +: EW]} + {1'b0, b[i*EW +: EW]};
      s[i*EW +: EW] = t[EW-1:0];
    end
    return s;
  endfunction

  function automatic logic [VW-1:0] rand_vec();
    logic [VW-1:0] v;
    for (int i = 0; i < LANES; i++) v[i*EW +: EW] = EW'($urandom);
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one instruction at a falling edge, check after the next rising edge
  task automatic issue(input logic [5:0] f, input logic [VW-1:0] a, input logic [VW-1:0] b);
    logic [VW-1:0] d, h, m, l;
    logic [9:0] ef;
    bit fill;
    d = rand_vec(); h = rand_vec(); m = rand_vec(); l = rand_vec();
    in_valid = 1'b1; func = f; src_a = a; src_b = b;
    dst_in = d; acc_hi_in = h; acc_mid_in = m; acc_lo_in = l;
    @(negedge clk);
    in_valid = 1'b0;
    ef = exp_flags(f);
    fill = ef[7];
    // R10: result is present one cycle after acceptance
    chk(out_valid == 1'b1, "R10", VW'(out_valid), VW'(1));
    // R9/R6/R7/R2/R5/R8: flag pattern
    chk({op_illegal, op_noop, op_en} == ef, "R9 R6 R7 flags", VW'({op_illegal, op_noop, op_en}), VW'(ef));
    chk(dst_we == fill && acc_lo_we == fill, "R8 R5 write enables",
        VW'({dst_we, acc_lo_we}), VW'({fill, fill}));
    if (fill) begin
      chk(dst_out == '0, "R2 dst zero", dst_out, '0);
      chk(acc_lo_out == exp_sum(a, b), "R3 lane sum", acc_lo_out, exp_sum(a, b));
      chk(acc_hi_out == h && acc_mid_out == m, "R4 upper slices",
          acc_hi_out ^ h | acc_mid_out ^ m, '0);
    end else begin
      chk(dst_out == d, "R5 R8 dst untouched", dst_out, d);
      chk(acc_lo_out == l, "R5 R8 acc_lo untouched", acc_lo_out, l);
    end
  endtask

  initial begin
    #1ms;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; func = '0;
    src_a = '0; src_b = '0; dst_in = '0;
    acc_hi_in = '0; acc_mid_in = '0; acc_lo_in = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!out_valid && op_en == '0 && !op_noop && !op_illegal && !dst_we && !acc_lo_we,
        "R1 reset", VW'({out_valid, op_en, op_noop, op_illegal, dst_we, acc_lo_we}), '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!out_valid, "R1 idle after release", VW'(out_valid), '0);

    // directed: every code once
    for (int c = 0; c < 64; c++) issue(6'(c), rand_vec(), rand_vec());

    // directed: wraparound in every lane (R3)
    issue(6'h12, {LANES{16'hFFFF}}, {LANES{16'h0001}});
    issue(6'h3E, {LANES{16'h8000}}, {LANES{16'h8000}});
    issue(6'h3F, rand_vec(), rand_vec());
    issue(6'h37, rand_vec(), rand_vec());

    // idle cycle: nothing flagged (R9, R10)
    @(negedge clk);
    chk(!out_valid && op_en == '0 && !op_noop && !op_illegal && !dst_we && !acc_lo_we,
        "R9 R10 idle", VW'({out_valid, op_en, op_noop, op_illegal, dst_we, acc_lo_we}), '0);

    // random stream with gaps
    for (int k = 0; k < 400; k++) begin
      if ($urandom_range(0, 3) == 0) begin
        @(negedge clk);
        chk(!out_valid && !dst_we && !acc_lo_we, "R10 gap", VW'({out_valid, dst_we, acc_lo_we}), '0);
      end
      issue(6'($urandom), rand_vec(), rand_vec());
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule